// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a virtual address into a physical address for an instruction fetch, a data read or a data write. It keeps two direct-mapped tables of one way each, one for code and one for data. Each entry has a match word, which carries the page tag and a valid flag, and a translate word, which carries the page frame and six access-right bits. A lookup compares the tag and checks the valid flag. It then applies the user or supervisor rights and either returns the physical address with its granted rights or reports a fault class. When a fault is reported, the faulting virtual address is captured.

Two conditions skip the tables. The first is translation being switched off. The second is a supervisor access to the low address window below a parameterised limit, which defaults to 0x2000. In both cases the address passes through unchanged with read and write granted. The tables are loaded through a simple write port that selects the table, the index and the word. Refill policy and the miss handler belong to the surrounding processor.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset, `rspValid` is 0, `faultAddr` is 0, and every match word in both tables reads as invalid, so any translated lookup misses.
- R2: A request sampled with `reqValid` high produces exactly one response: `rspValid` is high in the next cycle and low in any cycle that does not follow a request.
- R3: The page offset is the low 13 bits and the page number is the 19 bits above them. The entry index is the low 6 bits of the page number. A lookup hits only when match-word bits [31:13] equal the whole page number and match-word bit 0 (valid) is 1. Otherwise the result is a miss: code 1 for a fetch, code 2 for a data access.
- R4: On a successful translated lookup, `rspPhys` is translate-word bits [31:13] followed by the request's 13 offset bits.
- R5: Access kind 0 is a fetch. Its execute right is translate bit 4 in supervisor mode and bit 5 in user mode. A fetch without the right gives code 3. A granted fetch reports only `rspPermX`.
- R6: Kind 2 is a write, and kinds 1 and 3 are reads. Read and write rights are bits 0 and 1 in supervisor mode, and bits 2 and 3 in user mode. A write without the write right, or a read without the read right, gives code 4. A granted data access reports both of its rights.
- R7: A supervisor access below 0x2000 is not looked up. It returns its own address with read and write granted, no execute, and code 0. A user access in that range is translated normally.
- R8: Fetches consult only the code table, and all other kinds consult only the data table.
- R9: With `xlateEn` low, every request returns its own address with read and write granted, no execute, and code 0.
- R10: Each response with a nonzero code loads `faultAddr` with that request's virtual address. `faultAddr` is unchanged at all other times.
- R11: A response with a nonzero code has `rspPhys` 0 and all three right outputs 0.
- R12: A write with `wrEn` high stores `wrData` in the code table (`wrTable` 0) or the data table (`wrTable` 1), as the match word (`wrSel` 0) or the translate word (`wrSel` 1), at index `wrIdx`. A request in the following cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xlateEn | input | 1 | Translation enable |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Virtual address |
| reqKind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| supMode | input | 1 | Supervisor flag |
| wrEn | input | 1 | Table write strobe |
| wrTable | input | 1 | 0 code table, 1 data table |
| wrSel | input | 1 | 0 match word, 1 translate word |
| wrIdx | input | 6 | Entry index to write |
| wrData | input | 32 | Word to write |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspPhys | output | 32 | Physical address |
| rspPermR | output | 1 | Read granted |
| rspPermW | output | 1 | Write granted |
| rspPermX | output | 1 | Execute granted |
| rspExc | output | 3 | 0 none, 1 code miss, 2 data miss, 3 code page fault, 4 data page fault |
| faultAddr | output | 32 | Last faulting virtual address |

## Verification
The properties assume that a table write and a request never share a cycle. They also assume that the request inputs are settled at each clock edge. The stimulus keeps within both by separating table loads from lookups by at least one cycle and by changing inputs only on the falling edge. Request cycles alternate with idle cycles, so every response is followed by a cycle in which `rspValid` must be low. This makes the single-response rule observable for every lookup.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ALTRD = 2'd3
  } acc_kind_e;

  localparam logic [2:0] EXC_NONE   = 3'd0;
  localparam logic [2:0] EXC_IMISS  = 3'd1;
  localparam logic [2:0] EXC_DMISS  = 3'd2;
  localparam logic [2:0] EXC_IFAULT = 3'd3;
  localparam logic [2:0] EXC_DFAULT = 3'd4;

  // Access-right bit positions inside the translate word.
  localparam int RB_SUP_RD = 0;
  localparam int RB_SUP_WR = 1;
  localparam int RB_USR_RD = 2;
  localparam int RB_USR_WR = 3;
  localparam int RB_SUP_EX = 4;
  localparam int RB_USR_EX = 5;
  localparam int RIGHT_BITS = 6;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic       load;
    logic       identity;
    logic       fault;
    logic       useData;
    logic       grantR;
    logic       grantW;
    logic       grantX;
    logic [2:0] excCode;
  } xl_strobe_t;

endpackage

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [VA_W-1:0]            reqAddr,
  input  logic                       wrEn,
  input  logic                       wrTable,
  input  logic                       wrSel,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [VA_W-1:0]            wrData,
  input  xl_strobe_t                 strobe,
  output logic [1:0]                 tagHit,
  output logic [1:0]                 entValid,
  output logic [1:0][RIGHT_BITS-1:0] rightsAll,
  output logic                       rspValid,
  output logic [VA_W-1:0]            rspPhys,
  output logic                       rspPermR,
  output logic                       rspPermW,
  output logic                       rspPermX,
  output logic [2:0]                 rspExc,
  output logic [VA_W-1:0]            faultAddr
);

  localparam int VPN_W   = VA_W - PAGE_BITS;
  localparam int ENTRIES = 1 << IDX_W;

  logic [VPN_W-1:0]     reqVpn;
  logic [IDX_W-1:0]     reqIdx;
  logic [1:0][VPN_W-1:0] frameAll;

  assign reqVpn = reqAddr[VA_W-1:PAGE_BITS];
  assign reqIdx = reqVpn[IDX_W-1:0];

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    logic [VA_W-1:0] matchW [ENTRIES];
    logic [VA_W-1:0] transW [ENTRIES];
    logic [VA_W-1:0] mSel;
    logic [VA_W-1:0] tSel;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < ENTRIES; i++) matchW[i] <= '0;
      end else if (wrEn && (wrTable == 1'(t)) && !wrSel) begin
        matchW[wrIdx] <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (wrEn && (wrTable == 1'(t)) && wrSel) transW[wrIdx] <= wrData;
    end

    assign mSel         = matchW[reqIdx];
    assign tSel         = transW[reqIdx];
    assign tagHit[t]    = (mSel[VA_W-1:PAGE_BITS] == reqVpn);
    assign entValid[t]  = mSel[0];
    assign rightsAll[t] = tSel[RIGHT_BITS-1:0];
    assign frameAll[t]  = tSel[VA_W-1:PAGE_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspPhys   <= '0;
      rspPermR  <= 1'b0;
      rspPermW  <= 1'b0;
      rspPermX  <= 1'b0;
      rspExc    <= EXC_NONE;
      faultAddr <= '0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspExc <= strobe.excCode;
        if (strobe.fault) begin
          rspPhys   <= '0;
          rspPermR  <= 1'b0;
          rspPermW  <= 1'b0;
          rspPermX  <= 1'b0;
          faultAddr <= reqAddr;
        end else begin
          rspPermR <= strobe.grantR;
          rspPermW <= strobe.grantW;
          rspPermX <= strobe.grantX;
          if (strobe.identity) rspPhys <= reqAddr;
          else rspPhys <= {frameAll[strobe.useData], reqAddr[PAGE_BITS-1:0]};
        end
      end
    end
  end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int              VA_W         = 32,
  parameter logic [VA_W-1:0] BYPASS_LIMIT = 32'h2000
) (
  input  logic                       reqValid,
  input  logic [VA_W-1:0]            reqAddr,
  input  logic [1:0]                 reqKind,
  input  logic                       supMode,
  input  logic                       xlateEn,
  input  logic [1:0]                 tagHit,
  input  logic [1:0]                 entValid,
  input  logic [1:0][RIGHT_BITS-1:0] rightsAll,
  output xl_strobe_t                 strobe
);

  logic                  isFetch;
  logic                  isWrite;
  logic                  tblSel;
  logic                  inWindow;
  logic [RIGHT_BITS-1:0] rights;
  logic                  canR;
  logic                  canW;
  logic                  canX;

  assign isFetch  = (reqKind == ACC_FETCH);
  assign isWrite  = (reqKind == ACC_WRITE);
  assign tblSel   = !isFetch;
  assign inWindow = supMode && (reqAddr < BYPASS_LIMIT);
  assign rights   = rightsAll[tblSel];
  assign canR     = supMode ? rights[RB_SUP_RD] : rights[RB_USR_RD];
  assign canW     = supMode ? rights[RB_SUP_WR] : rights[RB_USR_WR];
  assign canX     = supMode ? rights[RB_SUP_EX] : rights[RB_USR_EX];

  always_comb begin
    strobe          = '0;
    strobe.load     = reqValid;
    strobe.useData  = tblSel;
    strobe.excCode  = EXC_NONE;
    if (!xlateEn || inWindow) begin
      strobe.identity = 1'b1;
      strobe.grantR   = 1'b1;
      strobe.grantW   = 1'b1;
    end else if (!(tagHit[tblSel] && entValid[tblSel])) begin
      strobe.fault   = 1'b1;
      strobe.excCode = isFetch ? EXC_IMISS : EXC_DMISS;
    end else if (isFetch) begin
      if (!canX) begin
        strobe.fault   = 1'b1;
        strobe.excCode = EXC_IFAULT;
      end else begin
        strobe.grantX = 1'b1;
      end
    end else begin
      if ((isWrite && !canW) || (!isWrite && !canR)) begin
        strobe.fault   = 1'b1;
        strobe.excCode = EXC_DFAULT;
      end else begin
        strobe.grantR = canR;
        strobe.grantW = canW;
      end
    end
  end

endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int              VA_W         = 32,
  parameter int              PAGE_BITS    = 13,
  parameter int              IDX_W        = 6,
  parameter logic [VA_W-1:0] BYPASS_LIMIT = 32'h2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xlateEn,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [1:0]       reqKind,
  input  logic             supMode,
  input  logic             wrEn,
  input  logic             wrTable,
  input  logic             wrSel,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VA_W-1:0]  wrData,
  output logic             rspValid,
  output logic [VA_W-1:0]  rspPhys,
  output logic             rspPermR,
  output logic             rspPermW,
  output logic             rspPermX,
  output logic [2:0]       rspExc,
  output logic [VA_W-1:0]  faultAddr
);

  xl_strobe_t                 strobe;
  logic [1:0]                 tagHit;
  logic [1:0]                 entValid;
  logic [1:0][RIGHT_BITS-1:0] rightsAll;

  xlate_ctrl #(.VA_W(VA_W), .BYPASS_LIMIT(BYPASS_LIMIT)) ctrl_i (
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqKind  (reqKind),
    .supMode  (supMode),
    .xlateEn  (xlateEn),
    .tagHit   (tagHit),
    .entValid (entValid),
    .rightsAll(rightsAll),
    .strobe   (strobe)
  );

  xlate_datapath #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .wrEn     (wrEn),
    .wrTable  (wrTable),
    .wrSel    (wrSel),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .strobe   (strobe),
    .tagHit   (tagHit),
    .entValid (entValid),
    .rightsAll(rightsAll),
    .rspValid (rspValid),
    .rspPhys  (rspPhys),
    .rspPermR (rspPermR),
    .rspPermW (rspPermW),
    .rspPermX (rspPermX),
    .rspExc   (rspExc),
    .faultAddr(faultAddr)
  );

endmodule

// File: rtl/addr_xlate_unit_chk.sv
module addr_xlate_unit_chk #(
  parameter int              VA_W         = 32,
  parameter int              PAGE_BITS    = 13,
  parameter logic [VA_W-1:0] BYPASS_LIMIT = 32'h2000
) (
  input logic            clk,
  input logic            rstN,
  input logic            xlateEn,
  input logic            reqValid,
  input logic [VA_W-1:0] reqAddr,
  input logic [1:0]      reqKind,
  input logic            supMode,
  input logic            rspValid,
  input logic [VA_W-1:0] rspPhys,
  input logic            rspPermR,
  input logic            rspPermW,
  input logic            rspPermX,
  input logic [2:0]      rspExc,
  input logic [VA_W-1:0] faultAddr
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R9
  passthru_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !xlateEn) |=>
      (rspPhys == $past(reqAddr) && rspExc == 3'd0 && rspPermR && rspPermW && !rspPermX));

  // R7
  low_window_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlateEn && supMode && (reqAddr < BYPASS_LIMIT)) |=>
      (rspPhys == $past(reqAddr) && rspExc == 3'd0 && rspPermR && rspPermW && !rspPermX));

  // R11
  fault_clears_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspExc != 3'd0) |->
      (rspPhys == '0 && !rspPermR && !rspPermW && !rspPermX));

  // R10
  fault_addr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspExc == 3'd0 || faultAddr == $past(reqAddr)));

  // R10
  fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rspValid || rspExc == 3'd0) |-> $stable(faultAddr));

  // R5
  fetch_side_codes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=> (rspExc == 3'd0 || rspExc == 3'd1 || rspExc == 3'd3));

  // R4
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspExc != 3'd0 || rspPhys[PAGE_BITS-1:0] == $past(reqAddr[PAGE_BITS-1:0])));

  // R6
  data_write_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2) |=> (rspExc != 3'd0 || rspPermW));

endmodule

bind addr_xlate_unit addr_xlate_unit_chk #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .BYPASS_LIMIT(BYPASS_LIMIT)
) chk_i (
  .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .reqValid(reqValid),
  .reqAddr(reqAddr), .reqKind(reqKind), .supMode(supMode),
  .rspValid(rspValid), .rspPhys(rspPhys), .rspPermR(rspPermR),
  .rspPermW(rspPermW), .rspPermX(rspPermX), .rspExc(rspExc),
  .faultAddr(faultAddr)
);

// File: tb/addr_xlate_unit_tb_top.sv
module addr_xlate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xlateEn = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        supMode = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrTable = 1'b0;
  logic        wrSel = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        rspValid;
  logic [31:0] rspPhys;
  logic        rspPermR, rspPermW, rspPermX;
  logic [2:0]  rspExc;
  logic [31:0] faultAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] shM [2][64];
  logic [31:0] shT [2][64];
  logic [31:0] expFault = '0;

  always #10 clk = ~clk;

  addr_xlate_unit dut_i (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqKind(reqKind), .supMode(supMode),
    .wrEn(wrEn), .wrTable(wrTable), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .rspValid(rspValid), .rspPhys(rspPhys),
    .rspPermR(rspPermR), .rspPermW(rspPermW), .rspPermX(rspPermX),
    .rspExc(rspExc), .faultAddr(faultAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeEntry(input bit tbl, input bit sel, input int idx, input logic [31:0] data);
    wrEn = 1'b1; wrTable = tbl; wrSel = sel; wrIdx = 6'(idx); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) shT[tbl][idx] = data;
    else     shM[tbl][idx] = data;
  endtask

  // Reference outcome from the requirements.
  task automatic lookup(input logic [31:0] addr, input logic [1:0] kind,
                        input bit sup, input bit en, input string req);
    logic [31:0] ePhys, m, tr;
    logic eR, eW, eX;
    logic [2:0] eExc;
    logic [18:0] vpn;
    bit t;
    vpn = addr[31:13];
    t = (kind != 2'd0);
    ePhys = '0; eR = 0; eW = 0; eX = 0; eExc = 3'd0;
    m = shM[t][vpn[5:0]];
    tr = shT[t][vpn[5:0]];
    if (!en || (sup && addr < 32'h2000)) begin
      ePhys = addr; eR = 1; eW = 1;
    end else if (m[31:13] != vpn || !m[0]) begin
      eExc = t ? 3'd2 : 3'd1;
    end else if (!t) begin
      if (!(sup ? tr[4] : tr[5])) eExc = 3'd3;
      else begin ePhys = {tr[31:13], addr[12:0]}; eX = 1; end
    end else begin
      eR = sup ? tr[0] : tr[2];
      eW = sup ? tr[1] : tr[3];
      if ((kind == 2'd2 && !eW) || (kind != 2'd2 && !eR)) begin
        eExc = 3'd4; eR = 0; eW = 0;
      end else ePhys = {tr[31:13], addr[12:0]};
    end
    if (eExc != 3'd0) expFault = addr;
    reqValid = 1'b1; reqAddr = addr; reqKind = kind; supMode = sup; xlateEn = en;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, "R2", "rspValid after request", 64'(rspValid), 64'd1);
    check({rspPhys, rspPermR, rspPermW, rspPermX, rspExc} === {ePhys, eR, eW, eX, eExc},
          req, "phys/R/W/X/exc",
          64'({rspPhys, rspPermR, rspPermW, rspPermX, rspExc}),
          64'({ePhys, eR, eW, eX, eExc}));
    check(faultAddr === expFault, "R10", "faultAddr", 64'(faultAddr), 64'(expFault));
    @(negedge clk);
    check(rspValid === 1'b0, "R2", "rspValid idle", 64'(rspValid), 64'd0);
  endtask

  function automatic logic [18:0] vpnFor(input int p);
    return {13'(p * 97 + 3), 6'(p)};
  endfunction

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 64; i++) begin shM[t][i] = '0; shT[t][i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rspValid === 1'b0, "R1", "rspValid in reset", 64'(rspValid), 64'd0);
    check(faultAddr === 32'd0, "R1", "faultAddr in reset", 64'(faultAddr), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid === 1'b0, "R1", "rspValid after reset", 64'(rspValid), 64'd0);
    lookup(32'h0004_2345, 2'd1, 1'b0, 1'b1, "R1/R3");
    lookup(32'h0123_4000, 2'd0, 1'b1, 1'b1, "R1/R3/R11");

    // R9: translation disabled
    for (int k = 0; k < 16; k++)
      lookup(32'hF000_0000 ^ 32'(k * 32'h0137_9ACF), 2'(k), k[2], 1'b0, "R9");

    // R7: supervisor low window, and its edges
    for (int k = 0; k < 4; k++) begin
      lookup(32'h0000_0000, 2'(k), 1'b1, 1'b1, "R7");
      lookup(32'h0000_1FFF, 2'(k), 1'b1, 1'b1, "R7");
      lookup(32'h0000_2000, 2'(k), 1'b1, 1'b1, "R7/R3");
      lookup(32'h0000_1ABC, 2'(k), 1'b0, 1'b1, "R7/R3");
    end

    // R5 R6 R4 R8 R12: sweep all right patterns, both tables, both modes
    for (int p = 0; p < 64; p++) begin
      logic [18:0] v;
      v = vpnFor(p);
      writeEntry(1'b0, 1'b0, p, {v, 12'd0, 1'b1});
      writeEntry(1'b0, 1'b1, p, {v ^ 19'h2A5A5, 7'd0, 6'(p)});
      writeEntry(1'b1, 1'b0, p, {v, 12'd0, 1'b1});
      writeEntry(1'b1, 1'b1, p, {v ^ 19'h15C3C, 7'd0, 6'(p)});
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++)
          lookup({v, 13'((p * 311 + k * 977) & 13'h1FFF)}, 2'(k), s[0], 1'b1,
                 (k == 0) ? "R4/R5/R8/R12" : "R4/R6/R8/R12");
    end

    // R3: tag mismatch and cleared valid flag
    for (int p = 0; p < 64; p += 5) begin
      logic [18:0] v;
      v = vpnFor(p) ^ 19'h40000;
      lookup({v, 13'h0ACE}, 2'd0, 1'b0, 1'b1, "R3/R11");
      lookup({v, 13'h1ACE}, 2'd2, 1'b1, 1'b1, "R3/R11");
      writeEntry(p[0], 1'b0, p, {vpnFor(p), 13'd0});
      lookup({vpnFor(p), 13'h0055}, 2'(p[0] ? 1 : 0), 1'b1, 1'b1, "R3/R12");
      lookup({vpnFor(p), 13'h0055}, 2'(p[0] ? 0 : 2), 1'b1, 1'b1, "R8");
    end

    // R8: entry present only in the code table
    writeEntry(1'b1, 1'b0, 63, 32'd0);
    writeEntry(1'b0, 1'b0, 63, {vpnFor(63), 13'd1});
    writeEntry(1'b0, 1'b1, 63, {19'h7_1234, 13'h3F});
    lookup({vpnFor(63), 13'h0FED}, 2'd0, 1'b0, 1'b1, "R8");
    lookup({vpnFor(63), 13'h0FED}, 2'd1, 1'b0, 1'b1, "R8");
    lookup({vpnFor(63), 13'h0FED}, 2'd0, 1'b1, 1'b1, "R8/R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule